// File: doc/BRIEF.md
# Omega Self-Routing Switch Fabric

An N×N multistage interconnect with N a power of two (8 by default), built from log2 N stages of N/2 two-by-two switches. Each input line presents a valid flag, a destination port address and a payload word. Lines are perfectly shuffled (index rotated left by one bit) ahead of every stage. Each switch steers a packet using only the destination bit belonging to its stage, most significant bit first. There is no central arbiter. Hardware cost grows as N·log2 N switch cells rather than N² crosspoints.

Each delivered packet leaves on the output port whose index equals its destination. Two packets can meet at one switch and ask for the same switch output. This can happen even when their final destinations differ. The packet on the upper switch input then proceeds, and the other is discarded. A per-input blocked flag reports which source lost. A parameter selects whether every stage ends in a register, giving a pipeline of log2 N cycles, or whether the fabric is purely combinational.

Top module: `omega_fabric`

## Requirements
- R1: A packet set in which every input i is valid with destination i is delivered completely, with every output valid and no blocked flag set.
- R2: A delivered packet appears on the output whose index equals its destination, with its payload unchanged. A cyclic shift (input i to destination (i+1) mod N) is delivered completely.
- R3: At the first stage, input i (upper) and input i+N/2 (lower) share a switch and are steered by destination bit n-1. When both are valid and that bit is equal, input i+N/2 is dropped and blocked_o[i+N/2] is set. At every stage the upper switch input wins a contention. When all inputs target output 0, only input 0 is delivered.
- R4: Distinct destinations can still collide inside the fabric. With N=8, input 0 to destination 0 and input 2 to destination 1 meet in the second stage: input 0 is delivered on output 0 and blocked_o[2] is set.
- R5: Every valid input is either delivered on exactly one output or flagged blocked, never both. The number of valid outputs plus blocked flags equals the number of valid inputs of the same packet set.
- R6: An input whose valid flag is low produces no output and never has its blocked flag set. It does not contend, whatever its destination.
- R7: With REG_STAGES=1 the results of a packet set appear log2 N clock cycles after it is presented. With REG_STAGES=0 they appear in the same cycle.
- R8: While rst_ni is low, all out_valid_o and blocked_o bits are zero, and packets in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the stage registers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | N_PORTS | Per-input packet present |
| in_dest_i | input | N_PORTS×ADDR_W | Per-input destination port address |
| in_data_i | input | N_PORTS×DATA_W | Per-input payload |
| out_valid_o | output | N_PORTS | Packet delivered on this output |
| out_data_o | output | N_PORTS×DATA_W | Payload delivered on each output |
| blocked_o | output | N_PORTS | Indexed by source: this input's packet was dropped |

## Verification
The bench builds two copies of the fabric with N_PORTS=8 and DATA_W=16: one with REG_STAGES=1 and one with REG_STAGES=0. Both receive the same stimulus. The eight-port size has three stages, so contention can be set up at the first stage, at the second stage between distinct destinations, and at every stage by a hot spot. The registered copy exposes the three-cycle latency and a reset taken while packets are in flight. The combinational copy shows the same routing decisions with no delay.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Perfect shuffle: rotate a w-bit line index left by one
  function automatic int unsigned shuffle_pos(input int unsigned idx, input int unsigned w);
    int unsigned msk;
    msk = (32'd1 << w) - 32'd1;
    return ((idx << 1) | (idx >> (w - 1))) & msk;
  endfunction

endpackage

// File: rtl/omega_sw2.sv
module omega_sw2 #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int SEL    = 2
) (
  input  logic              a_vld_i,
  input  logic [ADDR_W-1:0] a_dst_i,
  input  logic [DATA_W-1:0] a_dat_i,
  input  logic [ADDR_W-1:0] a_src_i,
  input  logic              b_vld_i,
  input  logic [ADDR_W-1:0] b_dst_i,
  input  logic [DATA_W-1:0] b_dat_i,
  input  logic [ADDR_W-1:0] b_src_i,
  output logic              u_vld_o,
  output logic [ADDR_W-1:0] u_dst_o,
  output logic [DATA_W-1:0] u_dat_o,
  output logic [ADDR_W-1:0] u_src_o,
  output logic              l_vld_o,
  output logic [ADDR_W-1:0] l_dst_o,
  output logic [DATA_W-1:0] l_dat_o,
  output logic [ADDR_W-1:0] l_src_o,
  output logic              clash_o
);

  logic a_up, a_dn, b_up, b_dn;

  always_comb begin
    a_up = a_vld_i & ~a_dst_i[SEL];
    a_dn = a_vld_i &  a_dst_i[SEL];
    // upper input has priority on contention
    b_up = b_vld_i & ~b_dst_i[SEL] & ~a_up;
    b_dn = b_vld_i &  b_dst_i[SEL] & ~a_dn;
    clash_o = a_vld_i & b_vld_i & (a_dst_i[SEL] == b_dst_i[SEL]);

    u_vld_o = a_up | b_up;
    u_dst_o = a_up ? a_dst_i : b_dst_i;
    u_dat_o = a_up ? a_dat_i : b_dat_i;
    u_src_o = a_up ? a_src_i : b_src_i;

    l_vld_o = a_dn | b_dn;
    l_dst_o = a_dn ? a_dst_i : b_dst_i;
    l_dat_o = a_dn ? a_dat_i : b_dat_i;
    l_src_o = a_dn ? a_src_i : b_src_i;
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int N_PORTS = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16,
  parameter int STG     = 0,
  parameter bit REG     = 1'b1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_PORTS-1:0]             vld_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] dst_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] dat_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] src_i,
  input  logic [N_PORTS-1:0]             blk_i,
  output logic [N_PORTS-1:0]             vld_o,
  output logic [N_PORTS-1:0][ADDR_W-1:0] dst_o,
  output logic [N_PORTS-1:0][DATA_W-1:0] dat_o,
  output logic [N_PORTS-1:0][ADDR_W-1:0] src_o,
  output logic [N_PORTS-1:0]             blk_o
);

  localparam int HALF = N_PORTS / 2;
  localparam int SEL  = ADDR_W - 1 - STG;

  logic [N_PORTS-1:0]             sh_vld, nx_vld;
  logic [N_PORTS-1:0][ADDR_W-1:0] sh_dst, nx_dst;
  logic [N_PORTS-1:0][DATA_W-1:0] sh_dat, nx_dat;
  logic [N_PORTS-1:0][ADDR_W-1:0] sh_src, nx_src;
  logic [N_PORTS-1:0]             nx_blk;
  logic [HALF-1:0]                clash;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_shuf
    localparam int P = int'(omega_pkg::shuffle_pos(i, ADDR_W));
    assign sh_vld[P] = vld_i[i];
    assign sh_dst[P] = dst_i[i];
    assign sh_dat[P] = dat_i[i];
    assign sh_src[P] = src_i[i];
  end

  for (genvar k = 0; k < HALF; k++) begin : g_sw
    omega_sw2 #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL(SEL)) u_sw (
      .a_vld_i (sh_vld[2*k]),   .a_dst_i (sh_dst[2*k]),
      .a_dat_i (sh_dat[2*k]),   .a_src_i (sh_src[2*k]),
      .b_vld_i (sh_vld[2*k+1]), .b_dst_i (sh_dst[2*k+1]),
      .b_dat_i (sh_dat[2*k+1]), .b_src_i (sh_src[2*k+1]),
      .u_vld_o (nx_vld[2*k]),   .u_dst_o (nx_dst[2*k]),
      .u_dat_o (nx_dat[2*k]),   .u_src_o (nx_src[2*k]),
      .l_vld_o (nx_vld[2*k+1]), .l_dst_o (nx_dst[2*k+1]),
      .l_dat_o (nx_dat[2*k+1]), .l_src_o (nx_src[2*k+1]),
      .clash_o (clash[k])
    );
  end

  // loser is always the lower switch input; flag it by source index
  always_comb begin
    nx_blk = blk_i;
    for (int k = 0; k < HALF; k++) begin
      if (clash[k]) nx_blk[sh_src[2*k+1]] = 1'b1;
    end
  end

  if (REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o <= '0;
        dst_o <= '0;
        dat_o <= '0;
        src_o <= '0;
        blk_o <= '0;
      end else begin
        vld_o <= nx_vld;
        dst_o <= nx_dst;
        dat_o <= nx_dat;
        src_o <= nx_src;
        blk_o <= nx_blk;
      end
    end
  end else begin : g_comb
    assign vld_o = nx_vld;
    assign dst_o = nx_dst;
    assign dat_o = nx_dat;
    assign src_o = nx_src;
    assign blk_o = nx_blk;
  end

endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
  parameter int  N_PORTS    = 8,
  parameter int  DATA_W     = 16,
  parameter bit  REG_STAGES = 1'b1,
  localparam int ADDR_W     = $clog2(N_PORTS),
  localparam int STAGES     = ADDR_W,
  localparam int LAT        = REG_STAGES ? STAGES : 0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_PORTS-1:0]             in_valid_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] in_dest_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] in_data_i,
  output logic [N_PORTS-1:0]             out_valid_o,
  output logic [N_PORTS-1:0][DATA_W-1:0] out_data_o,
  output logic [N_PORTS-1:0]             blocked_o
);

  if ((1 << ADDR_W) != N_PORTS || N_PORTS < 2) begin : g_bad_size
    $error("omega_fabric: N_PORTS must be a power of two, at least 2");
  end

  logic [STAGES:0][N_PORTS-1:0]             ln_vld;
  logic [STAGES:0][N_PORTS-1:0][ADDR_W-1:0] ln_dst;
  logic [STAGES:0][N_PORTS-1:0][DATA_W-1:0] ln_dat;
  logic [STAGES:0][N_PORTS-1:0][ADDR_W-1:0] ln_src;
  logic [STAGES:0][N_PORTS-1:0]             ln_blk;

  assign ln_vld[0] = in_valid_i;
  assign ln_dst[0] = in_dest_i;
  assign ln_dat[0] = in_data_i;
  assign ln_blk[0] = '0;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_src
    assign ln_src[0][i] = ADDR_W'(i);
  end

  for (genvar j = 0; j < STAGES; j++) begin : g_stg
    omega_stage #(
      .N_PORTS (N_PORTS),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .STG     (j),
      .REG     (REG_STAGES)
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (ln_vld[j]),   .dst_i (ln_dst[j]),   .dat_i (ln_dat[j]),
      .src_i  (ln_src[j]),   .blk_i (ln_blk[j]),
      .vld_o  (ln_vld[j+1]), .dst_o (ln_dst[j+1]), .dat_o (ln_dat[j+1]),
      .src_o  (ln_src[j+1]), .blk_o (ln_blk[j+1])
    );
  end

  assign out_valid_o = ln_vld[STAGES];
  assign out_data_o  = ln_dat[STAGES];
  assign blocked_o   = ln_blk[STAGES];

endmodule

// File: rtl/omega_fabric_chk.sv
module omega_fabric_chk #(
  parameter int N_PORTS = 8,
  parameter int ADDR_W  = 3,
  parameter int LAT     = 3
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [N_PORTS-1:0]             in_valid_i,
  input logic [N_PORTS-1:0][ADDR_W-1:0] in_dest_i,
  input logic [N_PORTS-1:0]             out_valid_o,
  input logic [N_PORTS-1:0]             blocked_o,
  input logic [N_PORTS-1:0][ADDR_W-1:0] fin_dest_i,
  input logic [N_PORTS-1:0][ADDR_W-1:0] fin_src_i
);

  localparam int HALF = N_PORTS / 2;

  // input history aligned with the outputs
  logic [LAT:0][N_PORTS-1:0]             hv;
  logic [LAT:0][N_PORTS-1:0][ADDR_W-1:0] hd;

  assign hv[0] = in_valid_i;
  assign hd[0] = in_dest_i;

  for (genvar t = 0; t < LAT; t++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hv[t+1] <= '0;
        hd[t+1] <= '0;
      end else begin
        hv[t+1] <= hv[t];
        hd[t+1] <= hd[t];
      end
    end
  end

  logic ident;
  always_comb begin
    ident = 1'b1;
    for (int i = 0; i < N_PORTS; i++) begin
      if (hd[LAT][i] != ADDR_W'(i)) ident = 1'b0;
    end
  end

  p_identity_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hv[LAT] == '1 && ident) |-> (blocked_o == '0 && out_valid_o == '1));

  for (genvar k = 0; k < N_PORTS; k++) begin : g_out
    p_land_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[k] |-> fin_dest_i[k] == ADDR_W'(k));
    p_origin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[k] |-> (hv[LAT][fin_src_i[k]] && !blocked_o[fin_src_i[k]]
                          && hd[LAT][fin_src_i[k]] == ADDR_W'(k)));
  end

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    p_upper_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hv[LAT][i] && hv[LAT][i+HALF] && hd[LAT][i][ADDR_W-1] == hd[LAT][i+HALF][ADDR_W-1])
      |-> blocked_o[i+HALF]);
  end

  p_conserve_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(out_valid_o) + $countones(blocked_o)) == $countones(hv[LAT]));

  p_idle_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocked_o & ~hv[LAT]) == '0);

  if (LAT > 0) begin : g_rst
    always_comb begin
      if (!rst_ni) begin
        p_reset_clear_r8: assert (out_valid_o == '0 && blocked_o == '0);
      end
    end
  end

endmodule

bind omega_fabric omega_fabric_chk #(
  .N_PORTS (N_PORTS),
  .ADDR_W  (ADDR_W),
  .LAT     (LAT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_dest_i   (in_dest_i),
  .out_valid_o (out_valid_o),
  .blocked_o   (blocked_o),
  .fin_dest_i  (ln_dst[STAGES]),
  .fin_src_i   (ln_src[STAGES])
);

// File: tb/sim_omega_fabric.sv
module sim_omega_fabric;

  localparam int N  = 8;
  localparam int AW = 3;
  localparam int DW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic [N-1:0]         vld;
  logic [N-1:0][AW-1:0] dst;
  logic [N-1:0][DW-1:0] dat;

  logic [N-1:0]         o0_vld, o1_vld, o0_blk, o1_blk;
  logic [N-1:0][DW-1:0] o0_dat, o1_dat;

  int errs = 0;
  int checks = 0;

  omega_fabric #(.N_PORTS(N), .DATA_W(DW), .REG_STAGES(1'b1)) u0 (
    .clk_i, .rst_ni, .in_valid_i(vld), .in_dest_i(dst), .in_data_i(dat),
    .out_valid_o(o0_vld), .out_data_o(o0_dat), .blocked_o(o0_blk));

  omega_fabric #(.N_PORTS(N), .DATA_W(DW), .REG_STAGES(1'b0)) u1 (
    .clk_i, .rst_ni, .in_valid_i(vld), .in_dest_i(dst), .in_data_i(dat),
    .out_valid_o(o1_vld), .out_data_o(o1_dat), .blocked_o(o1_blk));

  function automatic logic [DW-1:0] tag(input int i);
    return DW'(16'hC000 + i);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmp(input string req, input bit comb, input logic [N-1:0] ev,
                     input logic [N-1:0][DW-1:0] ed, input logic [N-1:0] eb);
    logic [N-1:0]         av, ab;
    logic [N-1:0][DW-1:0] ad;
    av = comb ? o1_vld : o0_vld;
    ab = comb ? o1_blk : o0_blk;
    ad = comb ? o1_dat : o0_dat;
    chk(av == ev, req, comb ? "comb valid" : "reg valid", 128'(av), 128'(ev));
    chk(ab == eb, req, comb ? "comb blocked" : "reg blocked", 128'(ab), 128'(eb));
    for (int k = 0; k < N; k++) begin
      if (ev[k]) chk(ad[k] == ed[k], req, "data", 128'(ad[k]), 128'(ed[k]));
    end
  endtask

  // Present one packet set, check the same-cycle copy, then the pipelined copy
  task automatic run_set(input string req, input logic [N-1:0] v,
                         input logic [N-1:0][AW-1:0] d, input logic [N-1:0] ev,
                         input logic [N-1:0][DW-1:0] ed, input logic [N-1:0] eb);
    @(negedge clk_i);
    vld = v;
    dst = d;
    #1;
    cmp(req, 1'b1, ev, ed, eb);
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(o0_vld == '0 && o0_blk == '0, "R7", "early output", 128'({o0_vld, o0_blk}), 128'(0));
    @(posedge clk_i);
    @(negedge clk_i);
    cmp(req, 1'b0, ev, ed, eb);
    vld = '0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_identity;
    logic [N-1:0][AW-1:0] d;
    logic [N-1:0][DW-1:0] ed;
    for (int i = 0; i < N; i++) begin
      d[i] = AW'(i);
      ed[i] = tag(i);
    end
    run_set("R1", '1, d, '1, ed, '0);
  endtask

  task automatic t_shift;
    logic [N-1:0][AW-1:0] d;
    logic [N-1:0][DW-1:0] ed;
    for (int i = 0; i < N; i++) begin
      d[i] = AW'((i + 1) % N);
      ed[(i + 1) % N] = tag(i);
    end
    run_set("R2", '1, d, '1, ed, '0);
  endtask

  task automatic t_first_stage_clash;
    logic [N-1:0][AW-1:0] d = '0;
    logic [N-1:0][DW-1:0] ed = '0;
    d[0] = 3'd0;
    d[4] = 3'd1;
    ed[0] = tag(0);
    run_set("R3", 8'h11, d, 8'h01, ed, 8'h10);
  endtask

  task automatic t_inner_clash;
    logic [N-1:0][AW-1:0] d = '0;
    logic [N-1:0][DW-1:0] ed = '0;
    d[0] = 3'd0;
    d[2] = 3'd1;
    ed[0] = tag(0);
    run_set("R4", 8'h05, d, 8'h01, ed, 8'h04);
  endtask

  task automatic t_hotspot;
    logic [N-1:0][AW-1:0] d = '0;
    logic [N-1:0][DW-1:0] ed = '0;
    ed[0] = tag(0);
    run_set("R5", '1, d, 8'h01, ed, 8'hFE);
  endtask

  task automatic t_idle_inputs;
    logic [N-1:0][AW-1:0] d;
    logic [N-1:0][DW-1:0] ed = '0;
    for (int i = 0; i < N; i++) d[i] = 3'd1;
    ed[1] = tag(4);
    // input 0 targets the same output but is not valid: no contention
    run_set("R6", 8'h10, d, 8'h02, ed, 8'h00);
  endtask

  task automatic t_reset_inflight;
    @(negedge clk_i);
    for (int i = 0; i < N; i++) dst[i] = AW'(i);
    vld = '1;
    @(posedge clk_i);
    @(negedge clk_i);
    vld = '0;
    rst_ni = 1'b0;
    #1;
    chk(o0_vld == '0 && o0_blk == '0, "R8", "flush", 128'({o0_vld, o0_blk}), 128'(0));
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(o0_vld == '0 && o0_blk == '0, "R8", "after flush", 128'({o0_vld, o0_blk}), 128'(0));
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    vld = '0;
    dst = '0;
    for (int i = 0; i < N; i++) dat[i] = tag(i);
    repeat (3) @(negedge clk_i);
    chk(o0_vld == '0 && o0_blk == '0, "R8", "in reset", 128'({o0_vld, o0_blk}), 128'(0));
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_identity();
    t_shift();
    t_first_stage_clash();
    t_inner_clash();
    t_hotspot();
    t_idle_inputs();
    t_reset_inflight();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule